// File: doc/BRIEF.md
# Indirect Configuration RAM Access Port

This block sits between a narrow host register bus and a set of internal configuration RAMs that are too large to map directly into the register space. The host sees three registers: a data register, a select register and a control register. A write to the select register names a bank, an entry index and a direction, and it starts one RAM transfer. A write-direction transfer copies the data register into the named entry. A read-direction transfer copies the entry into the data register.

Each transfer takes a fixed number of cycles, set by a parameter, to model RAM access latency. Bit 15 of the select register reads as 1 until the transfer has finished, and the host polls it before the next access. Three banks are modelled: receive timeslot configuration, transmit timeslot configuration and per-channel configuration. Accesses made while a transfer is still running are refused and recorded in a sticky error flag. A software reset bit clears the host-visible registers and leaves the RAM contents in place.

Top module: `cfg_indirect_port`

## Requirements
- R1: Host register address 0 is the data register, address 1 is the select register and address 2 is the control register. Reading address 1 returns bits 14:0 as last accepted, with the busy flag in bit 15. Reading address 2 returns the software reset bit in bit 0 and the sticky error flag in bit 1.
- R2: After an accepted select write, busy reads 1 for exactly LATENCY (default 4) consecutive cycles and then reads 0.
- R3: With select bit 14 = 0, the transfer stores the data register word into the addressed entry of the selected bank.
- R4: With select bit 14 = 1, the data register holds the addressed entry once busy has cleared.
- R5: Select bits 9:8 choose the bank: 01 is receive timeslot, 10 is transmit timeslot and 11 is channel. The timeslot banks are indexed by bits 6:0, so bit 7 is ignored. The channel bank is indexed by bits 7:0. The same index in different banks names independent entries.
- R6: Bank code 00 selects no RAM. A write transfer to it changes no entry, and a read transfer from it loads 0 into the data register.
- R7: A select-register write made while busy is ignored: the select value and the running transfer are unchanged. It sets the sticky error flag.
- R8: The data register keeps a read result until the next read transfer or the next host write to it. A write-direction transfer leaves it unchanged. A host write to it while busy is ignored and sets the sticky error flag.
- R9: While control bit 0 is 1, the data register, select register, busy flag and error flag read 0, and select writes start no transfer. RAM contents survive the software reset.
- R10: Entries hold full 16-bit words, so a timeslot entry with bit 15 (enable) set and a channel number in its low bits reads back intact.
- R11: After hardware reset, all three registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Register access strobe, one cycle per write |
| hostWe | input | 1 | 1 = write access |
| hostAddr | input | 2 | Register address |
| hostWdata | input | 16 | Write data |
| hostRdata | output | 16 | Read data for hostAddr (combinational) |

## Verification
A wrong busy counter shows on the select register's bit 15 within LATENCY+1 cycles of the select write. It appears either as a short or long busy window, or as a poll that never ends. A wrong bank or index decode does not show when the write happens. It shows later, when a read transfer of another bank or of an aliased index returns the wrong word, LATENCY cycles after that read is started. A lost refusal of a busy-time access shows up in two places: the select register readback while the transfer is still running, and the error bit immediately afterwards.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] ADDR_DATA = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_SEL  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd2;

  localparam int SEL_DIR_BIT = 14;
  localparam int BANK_LO     = 8;

  typedef enum logic [1:0] {
    BANK_NONE = 2'b00,
    BANK_RXTS = 2'b01,
    BANK_TXTS = 2'b10,
    BANK_CHAN = 2'b11
  } bank_t;

  typedef struct packed {
    logic ldData;
    logic ldSel;
    logic clrRegs;
    logic doXfer;
  } strobe_t;
endpackage

// File: rtl/cfg_ram_bank.sv
module cfg_ram_bank #(
  parameter int AW     = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostSel,
  input  logic              hostWe,
  input  logic [REG_AW-1:0] hostAddr,
  input  logic              hostWbit0,
  output strobe_t           strb,
  output logic              busy,
  output logic              errFlag,
  output logic              softRst
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [CNT_W-1:0] busyCnt;
  logic             wrData, wrSel, wrCtrl, acceptSel;

  assign wrData    = hostSel && hostWe && (hostAddr == ADDR_DATA);
  assign wrSel     = hostSel && hostWe && (hostAddr == ADDR_SEL);
  assign wrCtrl    = hostSel && hostWe && (hostAddr == ADDR_CTRL);
  assign busy      = (busyCnt != '0);
  assign acceptSel = wrSel && !busy && !softRst;

  always_comb begin
    strb         = '0;
    strb.ldData  = wrData && !busy && !softRst;
    strb.ldSel   = acceptSel;
    strb.clrRegs = softRst;
    strb.doXfer  = busy && (busyCnt == CNT_W'(1)) && !softRst;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyCnt <= '0;
      errFlag <= 1'b0;
      softRst <= 1'b0;
    end else begin
      if (wrCtrl) softRst <= hostWbit0;
      if (softRst) begin
        busyCnt <= '0;
        errFlag <= 1'b0;
      end else begin
        if (acceptSel)  busyCnt <= CNT_W'(LATENCY);
        else if (busy)  busyCnt <= busyCnt - CNT_W'(1);
        if (busy && (wrSel || wrData)) errFlag <= 1'b1;
      end
    end
  end

  // Checker-side count of busy cycles in the current window
  logic [CNT_W:0] runLen;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) runLen <= '0;
    else                 runLen <= runLen + 1'b1;
  end

  // R2: an undisturbed busy window lasts exactly LATENCY cycles
  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(softRst)) |-> (runLen == (CNT_W+1)'(LATENCY)));

  // R7: select write during busy raises the error flag
  p_reject_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wrSel && !softRst) |=> errFlag);

  // R7: the error flag is sticky outside software reset
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (errFlag && !softRst) |=> errFlag);
endmodule

// File: rtl/cfg_port_datapath.sv
module cfg_port_datapath
  import cfg_port_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int TS_AW   = 7,
  parameter int CH_AW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] dataReg,
  output logic [DATA_W-2:0] selReg
);
  localparam int NBANK = 3;

  logic              rdDir;
  bank_t             bankSel;
  logic [NBANK-1:0]  weVec;
  logic [DATA_W-1:0] bankRd [NBANK];
  logic [DATA_W-1:0] rdMux;

  assign rdDir   = selReg[SEL_DIR_BIT];
  assign bankSel = bank_t'(selReg[BANK_LO+1:BANK_LO]);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int AW = (b == NBANK - 1) ? CH_AW : TS_AW;
    assign weVec[b] = strb.doXfer && !rdDir && (bankSel == bank_t'(b + 1));
    cfg_ram_bank #(.AW(AW), .DATA_W(DATA_W)) u_ram (
      .clk   (clk),
      .we    (weVec[b]),
      .idx   (selReg[AW-1:0]),
      .wdata (dataReg),
      .rdata (bankRd[b])
    );
  end

  always_comb begin
    case (bankSel)
      BANK_RXTS: rdMux = bankRd[0];
      BANK_TXTS: rdMux = bankRd[1];
      BANK_CHAN: rdMux = bankRd[2];
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strb.clrRegs) begin
      dataReg <= '0;
      selReg  <= '0;
    end else begin
      if (strb.doXfer && rdDir) dataReg <= rdMux;
      else if (strb.ldData)     dataReg <= hostWdata;
      if (strb.ldSel) selReg <= hostWdata[DATA_W-2:0];
    end
  end

  // R8: data register changes only on a host load or a read completion
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.clrRegs && !strb.ldData && !(strb.doXfer && rdDir)) |=> $stable(dataReg));

  // R7: select register is frozen unless a select write was accepted
  p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.ldSel && !strb.clrRegs) |=> $stable(selReg));

  // R9: software reset zeroes host registers
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrRegs |=> (dataReg == '0 && selReg == '0));

  // R9: no RAM bank is written during software reset
  p_no_ram_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrRegs |-> (weVec == '0));
endmodule

// File: rtl/cfg_indirect_port.sv
module cfg_indirect_port
  import cfg_port_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int LATENCY = 4,
  parameter int TS_AW   = 7,
  parameter int CH_AW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostSel,
  input  logic              hostWe,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata
);
  strobe_t           strb;
  logic              busy, errFlag, softRst;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-2:0] selReg;

  cfg_port_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hostSel   (hostSel),
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostWbit0 (hostWdata[0]),
    .strb      (strb),
    .busy      (busy),
    .errFlag   (errFlag),
    .softRst   (softRst)
  );

  cfg_port_datapath #(.DATA_W(DATA_W), .TS_AW(TS_AW), .CH_AW(CH_AW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .hostWdata (hostWdata),
    .dataReg   (dataReg),
    .selReg    (selReg)
  );

  always_comb begin
    case (hostAddr)
      ADDR_DATA: hostRdata = dataReg;
      ADDR_SEL:  hostRdata = {busy, selReg};
      ADDR_CTRL: hostRdata = {{(DATA_W-2){1'b0}}, errFlag, softRst};
      default:   hostRdata = '0;
    endcase
  end
endmodule

// File: tb/cfg_indirect_port_bench.sv
module cfg_indirect_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hostSel = 1'b0;
  logic        hostWe = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic [15:0] hostWdata = 16'd0;
  logic [15:0] hostRdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_indirect_port u_cfg_indirect_port (
    .clk(clk), .rst_n(rst_n), .hostSel(hostSel), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata)
  );

  // {bank[1:0], index[7:0], read, wdata[15:0], expected[15:0]}
  localparam int NVEC = 14;
  localparam logic [42:0] VEC [NVEC] = '{
    {2'b01, 8'h05, 1'b0, 16'h8003, 16'h0000},
    {2'b10, 8'h05, 1'b0, 16'h8007, 16'h0000},
    {2'b11, 8'h05, 1'b0, 16'h1234, 16'h0000},
    {2'b11, 8'hFF, 1'b0, 16'hABCD, 16'h0000},
    {2'b01, 8'h7F, 1'b0, 16'h807F, 16'h0000},
    {2'b01, 8'h85, 1'b0, 16'h4444, 16'h0000},
    {2'b01, 8'h05, 1'b1, 16'hDEAD, 16'h4444},
    {2'b10, 8'h05, 1'b1, 16'hDEAD, 16'h8007},
    {2'b11, 8'h05, 1'b1, 16'hDEAD, 16'h1234},
    {2'b11, 8'hFF, 1'b1, 16'hDEAD, 16'hABCD},
    {2'b01, 8'h7F, 1'b1, 16'hDEAD, 16'h807F},
    {2'b00, 8'h05, 1'b0, 16'h5555, 16'h0000},
    {2'b00, 8'h05, 1'b1, 16'hDEAD, 16'h0000},
    {2'b10, 8'h85, 1'b1, 16'hDEAD, 16'h8007}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostSel = 1'b0; hostWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] d);
    hostAddr = a;
    #0.5;
    d = hostRdata;
  endtask

  task automatic waitIdle();
    logic [15:0] v;
    for (int i = 0; i < 40; i++) begin
      regRead(2'd1, v);
      if (!v[15]) return;
      @(negedge clk);
    end
    check("R2 busy never cleared", 16'h1, 16'h0);
  endtask

  function automatic logic [15:0] selWord(input logic rd, input logic [1:0] bank, input logic [7:0] idx);
    return {1'b0, rd, 4'b0000, bank, idx};
  endfunction

  task automatic transfer(input logic rd, input logic [1:0] bank, input logic [7:0] idx,
                          input logic [15:0] wd);
    regWrite(2'd0, wd);
    regWrite(2'd1, selWord(rd, bank, idx));
    waitIdle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    regRead(2'd0, v); check("R11 data after reset", v, 16'h0000);
    regRead(2'd1, v); check("R11 select after reset", v, 16'h0000);
    regRead(2'd2, v); check("R11 control after reset", v, 16'h0000);

    // Table walk: R3 R4 R5 R6 R10
    for (int k = 0; k < NVEC; k++) begin
      logic [42:0] e;
      e = VEC[k];
      transfer(e[32], e[42:41], e[40:33], e[31:16]);
      if (e[32]) begin
        regRead(2'd0, v);
        check($sformatf("R4/R5/R6/R10 vector %0d", k), v, e[15:0]);
      end
    end

    // R2 busy window of 4 cycles
    regWrite(2'd1, selWord(1'b1, 2'b01, 8'h7F));
    for (int c = 0; c < 4; c++) begin
      regRead(2'd1, v); check("R2 busy during window", {15'd0, v[15]}, 16'h1);
      @(negedge clk);
    end
    regRead(2'd1, v); check("R2 busy cleared after window", {15'd0, v[15]}, 16'h0);
    check("R1 select readback low bits", {1'b0, v[14:0]}, 16'h417F);

    // R8 hold across write-direction transfer, then host overwrite
    transfer(1'b1, 2'b11, 8'hFF, 16'h0000);
    regWrite(2'd1, selWord(1'b0, 2'b11, 8'h10));
    waitIdle();
    regRead(2'd0, v); check("R8 data kept after write transfer", v, 16'hABCD);
    regWrite(2'd0, 16'h1111);
    regRead(2'd0, v); check("R8 host write replaces data", v, 16'h1111);
    transfer(1'b1, 2'b11, 8'h10, 16'h0000);
    regRead(2'd0, v); check("R3 channel entry written from data", v, 16'hABCD);

    // R7 select write while busy, R8 data write while busy
    regWrite(2'd0, 16'h2020);
    regWrite(2'd1, selWord(1'b0, 2'b11, 8'h20));
    regWrite(2'd1, selWord(1'b1, 2'b01, 8'h05));
    regRead(2'd1, v); check("R7 select unchanged during busy", {1'b0, v[14:0]}, 16'h0320);
    regWrite(2'd0, 16'h9999);
    waitIdle();
    regRead(2'd2, v); check("R7 sticky error set", v, 16'h0002);
    regRead(2'd0, v); check("R8 busy-time data write ignored", v, 16'h2020);
    transfer(1'b1, 2'b11, 8'h20, 16'h0000);
    regRead(2'd0, v); check("R7 original transfer completed", v, 16'h2020);
    regRead(2'd2, v); check("R7 error still set", v, 16'h0002);

    // R9 software reset
    regWrite(2'd2, 16'h0001);
    @(negedge clk);
    regRead(2'd0, v); check("R9 data cleared", v, 16'h0000);
    regRead(2'd1, v); check("R9 select cleared", v, 16'h0000);
    regRead(2'd2, v); check("R9 error cleared", v, 16'h0001);
    regWrite(2'd1, selWord(1'b1, 2'b01, 8'h05));
    regRead(2'd1, v); check("R9 no transfer during reset", v, 16'h0000);
    regWrite(2'd2, 16'h0000);
    transfer(1'b1, 2'b01, 8'h05, 16'h0000);
    regRead(2'd0, v); check("R9 RAM kept across reset", v, 16'h4444);
    regRead(2'd2, v); check("R9 control clean after reset", v, 16'h0000);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule